// File: doc/BRIEF.md
# Streamed Multi-Word Program and Verify Sequencer

This block is the controller for a flash-style memory's streamed program command. Once an upstream decoder has accepted the command (a one-cycle `cmd_go_i` pulse), the block runs three phases in a fixed order. In the Program phase the host sends a start address and then a stream of words. The block writes each word to the next consecutive location of its word array. Writing can only clear bits, and each word keeps the block busy for a fixed number of cycles. In the Verify phase the host sends the same words again. The block compares each one against the array and reprograms a location when that is still possible. If a location cannot be repaired, the operation stops in an error state. In the Exit phase a single status read reports the result and returns the block to read mode.

After the first write of a phase, the host does not need to send full addresses. A write whose upper address field equals the phase's start address continues the stream, and a write whose upper field differs closes the phase. While the operation runs, every bus read returns a status word in place of array data. That status word holds a ready flag, a toggle flag that flips on each read, an error flag and a supply-error flag.

Top module: `mwp_seq`

## Requirements
- R1: After a synchronous active-low reset the block is in read mode: `busy_o`=0, every array word reads all ones, reads return array data, and the toggle flag is 0.
- R2: In read mode, writes have no effect on the array. A `cmd_go_i` pulse enters the Program phase. Its first accepted write latches the start address and programs the word at array index `addr % DEPTH`.
- R3: A later write whose bits 21..17 equal those of the start address is a continue write. It programs the next consecutive index, wrapping modulo DEPTH. Bits 16..0 of a continue write are ignored.
- R4: Programming only clears bits: the stored word becomes old AND written data, so a 0 never returns to 1.
- R5: Each program or reprogram keeps the block busy for PROG_CYCLES cycles. During that time the ready flag (status bit 7) reads 0, and writes are ignored.
- R6: A write whose bits 21..17 differ from the start address is a final write, and its data is ignored. In Program it moves the block to Verify. In Verify it moves the block to Exit.
- R7: While `busy_o`=1, every read returns status: bit 7 ready, bit 6 toggle, bit 5 error, bit 4 supply error, and all other bits 0. Before each Verify write the ready flag reads 1.
- R8: The toggle flag inverts on each read in the Program, Verify and error states. It does not change in read mode or in Exit.
- R9: On a Verify write, a matching word continues the stream. A mismatch is reprogrammed if the supply is good and no bit needs 0→1. Any other mismatch enters the error state with bit 5 = 1 and bit 4 = 1 only when `vpp_ok_i` was low.
- R10: In Exit, the first read returns status with ready=1, error=0 and an unchanged toggle. The block is then back in read mode.
- R11: `rst_cmd_i` and `cmd_go_i` are ignored while an operation runs. In the error state, writes and `cmd_go_i` are ignored, and only `rst_cmd_i` returns the block to read mode, clearing both error flags.
- R12: A Program write made while `vpp_ok_i` is low leaves the array word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go_i | input | 1 | Pulse: the streamed program command has been accepted |
| rst_cmd_i | input | 1 | Pulse: read/reset command |
| vpp_ok_i | input | 1 | Programming supply is within range |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | DATA_W | Bus write data |
| rd_en_i | input | 1 | Bus read strobe |
| rd_addr_i | input | ADDR_W | Bus read address |
| rd_data_o | output | DATA_W | Array word in read mode, status word otherwise |
| busy_o | output | 1 | An operation is in progress (not in read mode) |

## Verification
The bench builds the block with DEPTH=16 and PROG_CYCLES=3 and keeps the 22-bit address and 16-bit data defaults. The small array lets streams of up to eight words wrap past the last index. It also makes later operations land on locations that earlier ones already cleared, which produces both repairable mismatches and 0→1 verify failures. The short busy window lets the bench read status while the block is busy and also try writes that arrive too early.

// File: rtl/mwp_pkg.sv
// Package: shared state encoding and status bit positions for the
// streamed program/verify sequencer. Assumes DATA_W >= 8 in users.
package mwp_pkg;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_PFIRST  = 3'd1,
        ST_PSTREAM = 3'd2,
        ST_VFIRST  = 3'd3,
        ST_VSTREAM = 3'd4,
        ST_EXIT    = 3'd5,
        ST_ERR     = 3'd6
    } mwp_state_e;

    localparam int SB_READY  = 7;
    localparam int SB_TOGGLE = 6;
    localparam int SB_ERROR  = 5;
    localparam int SB_SUPPLY = 4;

    // True in states where a status read flips the toggle flag.
    function automatic logic toggles_in(input mwp_state_e s);
        return (s == ST_PFIRST) || (s == ST_PSTREAM) || (s == ST_VFIRST) ||
               (s == ST_VSTREAM) || (s == ST_ERR);
    endfunction

endpackage

// File: rtl/mwp_addr_unit.sv
// Address unit: holds the upper address field of the phase start and the
// current array index; classifies each write as continue or final.
// Assumes FIELD_HI < ADDR_W and IDX_W <= FIELD_LO.
module mwp_addr_unit #(
    parameter int ADDR_W   = 22,
    parameter int IDX_W    = 6,
    parameter int FIELD_LO = 17,
    parameter int FIELD_HI = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              is_cont_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic [IDX_W-1:0]  next_idx_o
);
    localparam int FW = FIELD_HI - FIELD_LO + 1;

    logic [FW-1:0]    start_field_q;
    logic [IDX_W-1:0] cur_idx_q;
    logic             unused_addr;

    assign unused_addr = ^wr_addr_i;

    // Latch start field and index on a first write; step index on continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_field_q <= '0;
            cur_idx_q     <= '0;
        end else if (latch_i) begin
            start_field_q <= wr_addr_i[FIELD_HI:FIELD_LO];
            cur_idx_q     <= wr_addr_i[IDX_W-1:0];
        end else if (step_i) begin
            cur_idx_q     <= cur_idx_q + 1'b1;
        end
    end

    assign is_cont_o  = (wr_addr_i[FIELD_HI:FIELD_LO] == start_field_q);
    assign cur_idx_o  = cur_idx_q;
    assign next_idx_o = cur_idx_q + 1'b1;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !latch_i |=> cur_idx_o == IDX_W'($past(cur_idx_o) + 1'b1)); // R3
    AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(start_field_q)); // R6

endmodule

// File: rtl/mwp_busy_timer.sv
// Busy timer: counts a fixed number of cycles after each program start.
// Assumes CYCLES >= 1.
module mwp_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load the full window on a start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i); // R5
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o); // R5

endmodule

// File: rtl/mwp_array.sv
// Word array model: resets to all ones, writes only clear bits (AND),
// one host read port and one compare read port, both combinational.
module mwp_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [IDX_W-1:0]  cidx_i,
    output logic [DATA_W-1:0] cdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Erase to all ones on reset; a write may only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (we_i) begin
            mem[widx_i] <= mem[widx_i] & wdata_i;
        end
    end

    assign rdata_o = mem[ridx_i];
    assign cdata_o = mem[cidx_i];

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem[$past(widx_i)] & ~$past(mem[widx_i])) == '0)); // R4

endmodule

// File: rtl/mwp_status.sv
// Status register: toggle flag flipped per read in active states, sticky
// supply-error flag; builds the status word returned on reads.
module mwp_status
    import mwp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mwp_state_e        state_i,
    input  logic              rd_en_i,
    input  logic              busy_i,
    input  logic              fail_i,
    input  logic              fail_sup_i,
    input  logic              clear_i,
    output logic [DATA_W-1:0] status_o
);
    logic tog_q;
    logic sup_q;

    // Flip the toggle flag on each read while an operation is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else if (rd_en_i && toggles_in(state_i))
            tog_q <= ~tog_q;
    end

    // Record whether a failure came from the programming supply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sup_q <= 1'b0;
        else if (clear_i)
            sup_q <= 1'b0;
        else if (fail_i)
            sup_q <= fail_sup_i;
    end

    // Assemble the status word; unused bits read zero.
    always_comb begin
        status_o            = '0;
        status_o[SB_READY]  = !busy_i;
        status_o[SB_TOGGLE] = tog_q;
        status_o[SB_ERROR]  = (state_i == ST_ERR);
        status_o[SB_SUPPLY] = sup_q;
    end

    AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !toggles_in(state_i) |=> $stable(tog_q)); // R8
    AST_SUPPLY_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        sup_q |-> state_i == ST_ERR); // R9

endmodule

// File: rtl/mwp_seq.sv
// Streamed program/verify sequencer top. Runs Program, Verify and Exit
// after an accepted command. Assumes DEPTH is a power of two, DATA_W >= 8,
// and the continue/final field lies above the index bits.
module mwp_seq
    import mwp_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 64,
    parameter int FIELD_LO    = 17,
    parameter int FIELD_HI    = 21,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go_i,
    input  logic              rst_cmd_i,
    input  logic              vpp_ok_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mwp_state_e        state_q, state_d;
    logic              latch, step, arr_we, tmr_load, tmr_busy;
    logic              fail, fail_sup, st_clear;
    logic              wr_ok, is_cont, first_wr, word_match, fixable;
    logic [IDX_W-1:0]  cur_idx, next_idx, tgt_idx;
    logic [DATA_W-1:0] arr_rdata, arr_cdata, status;
    logic              unused_rd;

    assign unused_rd = ^rd_addr_i;

    mwp_addr_unit #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIELD_LO(FIELD_LO), .FIELD_HI(FIELD_HI)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .latch_i(latch), .step_i(step),
        .wr_addr_i(wr_addr_i), .is_cont_o(is_cont),
        .cur_idx_o(cur_idx), .next_idx_o(next_idx)
    );

    mwp_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .busy_o(tmr_busy)
    );

    mwp_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we_i(arr_we), .widx_i(tgt_idx),
        .wdata_i(wr_data_i), .ridx_i(rd_addr_i[IDX_W-1:0]), .rdata_o(arr_rdata),
        .cidx_i(tgt_idx), .cdata_o(arr_cdata)
    );

    mwp_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .state_i(state_q), .rd_en_i(rd_en_i),
        .busy_i(tmr_busy), .fail_i(fail), .fail_sup_i(fail_sup),
        .clear_i(st_clear), .status_o(status)
    );

    // Target index: full address on a first write, next index otherwise.
    assign first_wr   = (state_q == ST_PFIRST) || (state_q == ST_VFIRST);
    assign tgt_idx    = first_wr ? wr_addr_i[IDX_W-1:0] : next_idx;
    assign wr_ok      = wr_en_i && !tmr_busy;
    assign word_match = (arr_cdata == wr_data_i);
    assign fixable    = vpp_ok_i && ((arr_cdata & wr_data_i) == wr_data_i);

    // Phase sequencing and per-write actions.
    always_comb begin
        state_d  = state_q;
        latch    = 1'b0;
        step     = 1'b0;
        arr_we   = 1'b0;
        tmr_load = 1'b0;
        fail     = 1'b0;
        fail_sup = 1'b0;
        st_clear = 1'b0;
        case (state_q)
            ST_READ: begin
                if (cmd_go_i) state_d = ST_PFIRST;
            end
            ST_PFIRST: begin
                if (wr_ok) begin
                    latch    = 1'b1;
                    tmr_load = 1'b1;
                    arr_we   = vpp_ok_i;
                    state_d  = ST_PSTREAM;
                end
            end
            ST_PSTREAM: begin
                if (wr_ok) begin
                    if (is_cont) begin
                        step     = 1'b1;
                        tmr_load = 1'b1;
                        arr_we   = vpp_ok_i;
                    end else begin
                        state_d = ST_VFIRST;
                    end
                end
            end
            ST_VFIRST, ST_VSTREAM: begin
                if (wr_ok) begin
                    if (state_q == ST_VFIRST || is_cont) begin
                        latch   = (state_q == ST_VFIRST);
                        step    = (state_q == ST_VSTREAM);
                        state_d = ST_VSTREAM;
                        if (!word_match) begin
                            if (fixable) begin
                                arr_we   = 1'b1;
                                tmr_load = 1'b1;
                            end else begin
                                fail     = 1'b1;
                                fail_sup = !vpp_ok_i;
                                state_d  = ST_ERR;
                            end
                        end
                    end else begin
                        state_d = ST_EXIT;
                    end
                end
            end
            ST_EXIT: begin
                if (rd_en_i) state_d = ST_READ;
            end
            ST_ERR: begin
                if (rst_cmd_i) begin
                    st_clear = 1'b1;
                    state_d  = ST_READ;
                end
            end
            default: state_d = ST_READ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    assign busy_o    = (state_q != ST_READ);
    assign rd_data_o = busy_o ? status : arr_rdata;

    AST_WRITE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !tmr_busy); // R5
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR) && !rst_cmd_i |=> state_q == ST_ERR); // R11
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> rd_data_o[3:0] == 4'h0); // R7
    AST_EXIT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT) && rd_en_i |=> !busy_o); // R10
    AST_CUR_IS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && !first_wr |=> cur_idx == $past(tgt_idx)); // R3

endmodule

// File: tb/tb_mwp_seq.sv
// Self-checking bench for mwp_seq: directed corners plus seeded random ops.
module tb_mwp_seq;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int DEP = 16;
    localparam int PC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_go = 1'b0, rst_cmd = 1'b0, vpp_ok = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic busy;

    mwp_seq #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .FIELD_LO(17),
              .FIELD_HI(21), .PROG_CYCLES(PC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_go_i(cmd_go), .rst_cmd_i(rst_cmd),
        .vpp_ok_i(vpp_ok), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .busy_o(busy)
    );

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [DW-1:0] model [DEP];
    logic etog = 1'b0;
    int mst = 0;  // 0 read, 1 program/verify, 2 exit, 3 error
    bit done = 1'b0;

    logic [DW-1:0] od [8];
    bit pv [8];
    bit vv [8];
    int on;
    logic [AW-1:0] osa;
    bit inject;

    function automatic logic [DW-1:0] stat(input bit rdy, input bit tg,
                                           input bit er, input bit sp);
        return DW'({rdy, tg, er, sp, 4'h0});
    endfunction

    function automatic int ix(input logic [AW-1:0] a, input int k);
        return (int'(a % DEP) + k) % DEP;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 v = rd_data;
        if (mst == 1 || mst == 3) etog = ~etog;
        if (mst == 2) mst = 0;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(posedge clk); #1 s = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] cont_addr(input logic [4:0] f);
        return {f, 17'($urandom)};
    endfunction

    task automatic run_op();
        logic [DW-1:0] v, cur;
        logic [4:0] fld;
        bit failed, sup;
        bit t;
        fld = osa[21:17];
        failed = 1'b0; sup = 1'b0;
        pulse(cmd_go);
        mst = 1;
        chk("R2 busy after command", busy, 1'b1);
        for (int k = 0; k < on; k++) begin
            vpp_ok = pv[k];
            wr(k == 0 ? osa : cont_addr(fld), od[k]);
            vpp_ok = 1'b1;
            if (pv[k]) model[ix(osa, k)] = model[ix(osa, k)] & od[k];
            if (inject && k == 0) begin
                wr(cont_addr(fld), '0);  // too early: ignored (R5)
                pulse(rst_cmd);          // ignored while running (R11)
            end
            t = etog; rd('0, v);
            chk("R5 ready low while busy", v, stat(0, t, 0, 0));
            wait_cyc(PC + 1);
        end
        wr({fld ^ 5'(1 + $urandom % 31), 17'($urandom)}, DW'($urandom));  // R6
        for (int k = 0; k < on; k++) begin
            t = etog; rd('0, v);
            chk("R7 ready before verify write", v, stat(1, t, 0, 0));
            vpp_ok = vv[k];
            wr(k == 0 ? osa : cont_addr(fld), od[k]);
            vpp_ok = 1'b1;
            cur = model[ix(osa, k)];
            if (cur != od[k]) begin
                if (vv[k] && ((cur & od[k]) == od[k])) begin
                    model[ix(osa, k)] = od[k];
                    wait_cyc(PC + 1);
                end else begin
                    failed = 1'b1; sup = !vv[k]; mst = 3;
                    break;
                end
            end
        end
        if (!failed) begin
            wr({fld ^ 5'(1 + $urandom % 31), 17'($urandom)}, DW'($urandom));
            mst = 2;
            t = etog; rd('0, v);
            chk("R10 exit status", v, stat(1, t, 0, 0));
            chk("R10 read mode after exit", busy, 1'b0);
        end else begin
            t = etog; rd('0, v);
            chk("R9 error status", v, stat(1, t, 1, sup));
            t = etog; rd('0, v);
            chk("R8 toggle flips in error", v[6], t);
            wr(osa, '0);
            pulse(cmd_go);
            t = etog; rd('0, v);
            chk("R11 error held after write and cmd_go", v, stat(1, t, 1, sup));
            pulse(rst_cmd);
            mst = 0;
            chk("R11 read/reset leaves error", busy, 1'b0);
        end
        for (int k = 0; k < on; k++) begin
            rd(AW'(ix(osa, k)), v);
            chk("R4 array word after op", v, model[ix(osa, k)]);
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEP; i++) model[i] = '1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        chk("R1 busy_o after reset", busy, 1'b0);
        rd(22'd0, v);  chk("R1 word 0 erased", v, 16'hFFFF);
        rd(22'd15, v); chk("R1 last word erased", v, 16'hFFFF);
        // R2: write in read mode has no effect
        wr(22'd5, 16'h0000);
        rd(22'd5, v);  chk("R2 write ignored in read mode", v, 16'hFFFF);
        // Directed: wrap past last index, early write and reset ignored
        osa = {5'd3, 17'd14}; on = 4; inject = 1'b1;
        od[0] = 16'hA5F0; od[1] = 16'h0F0F; od[2] = 16'h1234; od[3] = 16'hFFFE;
        for (int k = 0; k < 8; k++) begin pv[k] = 1'b1; vv[k] = 1'b1; end
        run_op();
        rd(22'd2, v); chk("R3 word past stream untouched", v, 16'hFFFF);
        rd(22'd0, v); chk("R3 wrapped index programmed", v, 16'h1234);
        inject = 1'b0;
        // Directed: supply low in both phases -> supply error (R12, R9)
        osa = {5'd9, 17'd8}; on = 2;
        od[0] = 16'h00FF; od[1] = 16'hFF00;
        pv[0] = 1'b0; vv[0] = 1'b0;
        run_op();
        rd(22'd8, v); chk("R12 unpowered write left word", v, 16'hFFFF);
        pv[0] = 1'b1; vv[0] = 1'b1;
        // Directed: bit needing 0->1 -> error without supply flag (R9)
        osa = {5'd1, 17'd14}; on = 1; od[0] = 16'hFFFF;
        run_op();
        // Random operations
        for (int n = 0; n < 40; n++) begin
            on = 1 + $urandom % 8;
            osa = {5'($urandom), 17'($urandom)};
            for (int k = 0; k < on; k++) begin
                od[k] = ($urandom % 2 == 0) ? (DW'($urandom) & model[ix(osa, k)])
                                            : DW'($urandom);
                pv[k] = ($urandom % 8) != 0;
                vv[k] = ($urandom % 8) != 0;
            end
            run_op();
            for (int j = 0; j < 3; j++) begin
                int a;
                a = $urandom % DEP;
                rd({5'($urandom), 17'(a)}, v);
                chk("R1 read mode returns array", v, model[a]);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule